// File: doc/BRIEF.md
# Task Trigger Load Generator

This block drives the start inputs of a bank of real-time tasks so that any chosen subset of them runs continuously. A host writes an enable mask through a small word-wide register port. Each enabled task gets a one-cycle start pulse. Every time the task reports that it has finished, the block starts it again, so the task keeps running back to back. The host can change the running set at any time, which lets an external controller step the system load through arbitrary combinations.

Mask writes go into a staging copy one word at a time. A separate commit strobe copies the whole staged mask into the active mask in a single cycle, so no partial combination is ever seen. Each commit that changes the active mask raises a one-cycle change flag. It also captures the value of a free-running cycle counter, so that load changes can be lined up with external measurements.

Top module: `task_trigger_gen`

## Requirements
- R1: While reset is held (synchronous, active low), and in the first cycle after it, the active mask is all zero, no trigger is asserted, `chg_valid` is 0, `chg_stamp` is 0 and `host_rdata` reads zero.
- R2: A write (`host_wr`=1) stores `host_wdata` into staging word `host_addr`, where word k holds tasks k*WORD_W up to k*WORD_W+WORD_W-1 with the lowest task in bit 0. The write alone changes neither the triggers nor `host_rdata`, which always shows the active mask word selected by `host_addr`.
- R3: A commit (`host_commit`=1) copies the entire staged mask into the active mask on that clock edge. A write made in the same cycle as the commit is included in it.
- R4: A task whose active enable is set while it is idle receives a trigger pulse exactly one cycle wide in the cycle right after the commit.
- R5: For an enabled task that is running, `task_done` sampled high in cycle k produces a trigger in cycle k+1.
- R6: An enabled running task receives no further trigger until its done is seen, so a trigger is never asserted in two consecutive cycles without an intervening done.
- R7: Disabling a task does not abort its current run but suppresses every later trigger. Done from a disabled task is ignored. A task re-enabled while still running waits for its done before it is triggered.
- R8: A commit that changes the active mask produces a one-cycle `chg_valid` in the next cycle, with `chg_stamp` equal to the number of clock cycles between reset release and the commit cycle.
- R9: A commit that leaves the active mask unchanged raises no `chg_valid`, and `chg_stamp` keeps its value.
- R10: Writes to an address at or above the number of mask words are ignored and read back as zero. Bits of the top word above the last task are dropped and read as zero.
- R11: Any combination of tasks may be enabled together. All tasks newly enabled by one commit trigger in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Write strobe for the staging mask word |
| host_addr | input | ADDR_W | Mask word index for writes and reads |
| host_wdata | input | WORD_W | Data written to the staging word |
| host_commit | input | 1 | Copy the staged mask into the active mask |
| host_rdata | output | WORD_W | Active mask word at host_addr |
| task_done | input | NUM_TASKS | Per-task completion indication |
| task_trig | output | NUM_TASKS | Per-task one-cycle start pulse |
| chg_valid | output | 1 | One-cycle flag after a mask-changing commit |
| chg_stamp | output | TS_W | Cycle count captured at the last mask change |

## Verification
The restart path is exercised in three ways. Done pulses are driven on running tasks, which shows the one-cycle restart latency. Done pulses are also driven on idle or disabled tasks, which separates a real restart from a spurious one. Disable and re-enable while a task is still running shows that pending runs are neither aborted nor triggered twice. Commits are tested both with and without a write in the same cycle, with unchanged masks and with out-of-range addresses, which tells the change event apart from a plain commit. A long random phase mixes writes, commits and done patterns against a cycle model to cover combinations that the directed cases do not reach.

// File: rtl/ttg_pkg.sv
// Shared helpers and types for the task trigger load generator.
// Assumes only elaboration-time use of the functions.
package ttg_pkg;

    // Number of words needed to cover n bits in w-bit words.
    function automatic int ceil_div(input int n, input int w);
        return (n + w - 1) / w;
    endfunction

    // Per-task lane state: idle, issuing the start pulse, or running.
    typedef enum logic [1:0] {
        LANE_IDLE = 2'd0,
        LANE_PULSE = 2'd1,
        LANE_RUN = 2'd2
    } lane_state_e;

endpackage

// File: rtl/ttg_mask_bank.sv
// Staging and active enable masks with a word-wide host port.
// Writes land in the staging copy; a commit moves the whole staging copy
// (including a same-cycle write) into the active copy in one edge.
// Assumes ADDR_W can express NUM_WORDS, so out-of-range addresses exist.
module ttg_mask_bank #(
    parameter int N         = 60,
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 4,
    parameter int ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              commit,
    output logic [N-1:0]      act_mask,
    output logic [N-1:0]      act_next,
    output logic [WORD_W-1:0] rdata,
    output logic              changed
);
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    logic [N-1:0]      shadow_q;
    logic [N-1:0]      shadow_next;
    logic [N-1:0]      act_q;
    logic              in_range;
    logic [IDX_W-1:0]  word_idx;
    logic [WORD_W-1:0] act_words [NUM_WORDS];

    // Address decode shared by write and read paths.
    assign in_range = (int'(addr) < NUM_WORDS);
    assign word_idx = addr[IDX_W-1:0];

    // Per-word slicing; the last word may be partial.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam int LO = w * WORD_W;
        localparam int HI = ((LO + WORD_W) < N) ? (LO + WORD_W - 1) : (N - 1);
        localparam int SW = HI - LO + 1;
        logic hit;
        assign hit = wr && in_range && (addr == ADDR_W'(w));
        assign shadow_next[HI:LO] = hit ? wdata[SW-1:0] : shadow_q[HI:LO];
        assign act_words[w] = WORD_W'(act_q[HI:LO]);
    end

    // Next active mask and change detection for the event logic.
    always_comb begin
        act_next = commit ? shadow_next : act_q;
        changed  = commit && (shadow_next != act_q);
        rdata    = in_range ? act_words[word_idx] : '0;
    end

    // Register both mask copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            act_q    <= '0;
        end else begin
            shadow_q <= shadow_next;
            act_q    <= act_next;
        end
    end

    assign act_mask = act_q;
endmodule

// File: rtl/ttg_task_lane.sv
// One task's start/restart sequencer.
// Starts the task when enabled and idle, or when enabled and done is seen
// while running; the start pulse is registered, one cycle wide.
// Assumes done is only meaningful while the lane is busy.
module ttg_task_lane
    import ttg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_next,
    input  logic done,
    output logic trig,
    output logic busy
);
    lane_state_e state_q;
    lane_state_e state_d;
    logic        start;

    // Start decision and next state.
    always_comb begin
        busy  = (state_q != LANE_IDLE);
        start = enable_next && (!busy || done);
        if (start) begin
            state_d = LANE_PULSE;
        end else if (busy && done) begin
            state_d = LANE_IDLE;
        end else if (state_q == LANE_PULSE) begin
            state_d = LANE_RUN;
        end else begin
            state_d = state_q;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LANE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign trig = (state_q == LANE_PULSE);
endmodule

// File: rtl/ttg_stamp.sv
// Free-running cycle counter with a change event capture.
// On a change event the current count is latched and a one-cycle valid
// flag follows. The counter wraps at 2**TS_W.
module ttg_stamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            event_in,
    output logic            chg_valid,
    output logic [TS_W-1:0] chg_stamp
);
    logic [TS_W-1:0] cnt_q;

    // Cycle counter, zero in the first cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Capture the count and flag the event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_valid <= 1'b0;
            chg_stamp <= '0;
        end else begin
            chg_valid <= event_in;
            if (event_in) begin
                chg_stamp <= cnt_q;
            end
        end
    end
endmodule

// File: rtl/task_trigger_gen.sv
// Top level of the task trigger load generator.
// Holds the host-controlled enable mask, one lane per task and the change
// timestamp. Lanes see the next active mask so a newly enabled task is
// started in the cycle right after the commit.
module task_trigger_gen
    import ttg_pkg::*;
#(
    parameter int  NUM_TASKS = 60,
    parameter int  WORD_W    = 16,
    parameter int  TS_W      = 32,
    localparam int NUM_WORDS = ceil_div(NUM_TASKS, WORD_W),
    localparam int ADDR_W    = $clog2(NUM_WORDS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [WORD_W-1:0]    host_wdata,
    input  logic                 host_commit,
    output logic [WORD_W-1:0]    host_rdata,
    input  logic [NUM_TASKS-1:0] task_done,
    output logic [NUM_TASKS-1:0] task_trig,
    output logic                 chg_valid,
    output logic [TS_W-1:0]      chg_stamp
);
    logic [NUM_TASKS-1:0] act_mask;
    logic [NUM_TASKS-1:0] act_next;
    logic [NUM_TASKS-1:0] busy_vec;
    logic                 mask_changed;

    ttg_mask_bank #(
        .N         (NUM_TASKS),
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W)
    ) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (host_wr),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .commit   (host_commit),
        .act_mask (act_mask),
        .act_next (act_next),
        .rdata    (host_rdata),
        .changed  (mask_changed)
    );

    for (genvar i = 0; i < NUM_TASKS; i++) begin : g_lane
        ttg_task_lane u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .enable_next (act_next[i]),
            .done        (task_done[i]),
            .trig        (task_trig[i]),
            .busy        (busy_vec[i])
        );
    end

    ttg_stamp #(
        .TS_W (TS_W)
    ) u_stamp (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_in  (mask_changed),
        .chg_valid (chg_valid),
        .chg_stamp (chg_stamp)
    );
endmodule

// File: rtl/ttg_checker.sv
// Property checker for task_trigger_gen, attached by bind.
// Observes ports plus the active mask and per-lane busy flags.
module ttg_checker #(
    parameter int N    = 60,
    parameter int TS_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            host_commit,
    input logic [N-1:0]    task_done,
    input logic [N-1:0]    task_trig,
    input logic [N-1:0]    busy_vec,
    input logic [N-1:0]    act_mask,
    input logic            chg_valid,
    input logic [TS_W-1:0] chg_stamp
);
    // R1: reset leaves outputs quiet.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (task_trig == '0 && !chg_valid && chg_stamp == '0));

    // R3: the active mask only moves after a commit.
    a_r3_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(host_commit) |-> $stable(act_mask));

    // R4 / R7: triggers only go to enabled tasks.
    a_r4_trig_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (task_trig & ~act_mask) == '0);

    // R5: a trigger follows either an idle lane or a seen done.
    a_r5_trig_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (task_trig & ~$past(task_done | ~busy_vec)) == '0);

    // R6: no back-to-back trigger without a done in between.
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (task_trig & $past(task_trig) & ~$past(task_done)) == '0);

    // R8: change flag only after a commit that moved the mask.
    a_r8_chg_cause: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> ($past(host_commit) && act_mask != $past(act_mask)));

    // R9: the stamp holds when no change is flagged.
    a_r9_stamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_valid |-> $stable(chg_stamp));
endmodule

bind task_trigger_gen ttg_checker #(
    .N    (NUM_TASKS),
    .TS_W (TS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_commit (host_commit),
    .task_done   (task_done),
    .task_trig   (task_trig),
    .busy_vec    (busy_vec),
    .act_mask    (act_mask),
    .chg_valid   (chg_valid),
    .chg_stamp   (chg_stamp)
);

// File: tb/task_trigger_gen_bench.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a cycle model built from the requirements.
module task_trigger_gen_bench;
    localparam int N    = 60;
    localparam int W    = 16;
    localparam int TS   = 32;
    localparam int NW   = (N + W - 1) / W;
    localparam int AW   = $clog2(NW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [W-1:0]  host_wdata = '0;
    logic          host_commit = 1'b0;
    logic [W-1:0]  host_rdata;
    logic [N-1:0]  task_done = '0;
    logic [N-1:0]  task_trig;
    logic          chg_valid;
    logic [TS-1:0] chg_stamp;

    int n_checks = 0;
    int n_err = 0;

    // Reference model state.
    logic [N-1:0]  m_shadow = '0;
    logic [N-1:0]  m_act = '0;
    logic [N-1:0]  m_busy = '0;
    logic [N-1:0]  m_trig = '0;
    logic          m_chg = 1'b0;
    logic [TS-1:0] m_stamp = '0;
    logic [TS-1:0] m_cnt = '0;

    always #5 clk = ~clk;

    task_trigger_gen #(.NUM_TASKS(N), .WORD_W(W), .TS_W(TS)) u_task_trigger_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_commit (host_commit),
        .host_rdata  (host_rdata),
        .task_done   (task_done),
        .task_trig   (task_trig),
        .chg_valid   (chg_valid),
        .chg_stamp   (chg_stamp)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Word a of a mask, zero when out of range (R2, R10).
    function automatic logic [W-1:0] word_of(input logic [N-1:0] m, input int a);
        logic [NW*W-1:0] p;
        p = '0;
        p[N-1:0] = m;
        if (a >= NW) return '0;
        return p[a*W +: W];
    endfunction

    // Staging mask after an optional write (R2, R10).
    function automatic logic [N-1:0] put_word(input logic [N-1:0] m, input bit wr,
                                              input int a, input logic [W-1:0] d);
        logic [NW*W-1:0] p;
        p = '0;
        p[N-1:0] = m;
        if (wr && a < NW) p[a*W +: W] = d;
        return p[N-1:0];
    endfunction

    // One clock cycle: drive, model, clock, compare at the falling edge.
    task automatic cyc(input bit wr, input int a, input logic [W-1:0] d,
                       input bit cm, input logic [N-1:0] dn);
        logic [N-1:0] sh_n, act_n, start;
        logic chg_n;
        host_wr = wr;
        host_addr = AW'(a);
        host_wdata = d;
        host_commit = cm;
        task_done = dn;
        #1;
        check(host_rdata == word_of(m_act, a), "R2 readback", 64'(host_rdata), 64'(word_of(m_act, a)));
        sh_n  = put_word(m_shadow, wr, a, d);
        act_n = cm ? sh_n : m_act;
        start = act_n & (~m_busy | dn);
        chg_n = cm && (sh_n != m_act);
        @(posedge clk);
        m_busy   = start | (m_busy & ~dn);
        m_trig   = start;
        m_chg    = chg_n;
        if (chg_n) m_stamp = m_cnt;
        m_shadow = sh_n;
        m_act    = act_n;
        m_cnt    = m_cnt + 1;
        @(negedge clk);
        check(task_trig == m_trig, "R5 trig model", 64'(task_trig), 64'(m_trig));
        check(chg_valid == m_chg, "R8 chg model", 64'(chg_valid), 64'(m_chg));
        check(chg_stamp == m_stamp, "R8 stamp model", 64'(chg_stamp), 64'(m_stamp));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, '0, 0, '0);
    endtask

    task automatic peek(input int a, input logic [W-1:0] exp, input string tag);
        host_wr = 1'b0;
        host_commit = 1'b0;
        host_addr = AW'(a);
        #1;
        check(host_rdata == exp, tag, 64'(host_rdata), 64'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [N-1:0] mask_a;
        logic [TS-1:0] c_commit, s_prev;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(task_trig == '0, "R1 trig", 64'(task_trig), 64'h0);
        check(chg_valid == 1'b0, "R1 chg", 64'(chg_valid), 64'h0);
        check(chg_stamp == '0, "R1 stamp", 64'(chg_stamp), 64'h0);
        peek(0, '0, "R1 rdata");
        rst_n = 1'b1;
        idle(2);

        // R2: staged write alone has no effect
        cyc(1, 0, 16'h0005, 0, '0);
        idle(2);
        peek(0, '0, "R2 staged");
        check(task_trig == '0, "R2 no trig", 64'(task_trig), 64'h0);

        // R3 / R11 / R4 / R8: commit with a same-cycle write
        cyc(1, 1, 16'h8001, 0, '0);
        c_commit = m_cnt;
        cyc(1, 2, 16'h0010, 1, '0);
        mask_a = '0;
        mask_a[0] = 1'b1; mask_a[2] = 1'b1; mask_a[16] = 1'b1;
        mask_a[31] = 1'b1; mask_a[36] = 1'b1;
        check(task_trig == mask_a, "R11 joint start", 64'(task_trig), 64'(mask_a));
        check(chg_valid == 1'b1, "R8 chg", 64'(chg_valid), 64'h1);
        check(chg_stamp == c_commit, "R8 stamp", 64'(chg_stamp), 64'(c_commit));
        peek(0, 16'h0005, "R3 word0");
        peek(1, 16'h8001, "R3 word1");
        peek(2, 16'h0010, "R3 word2");
        idle(1);
        check(task_trig == '0, "R4 one cycle", 64'(task_trig), 64'h0);
        check(chg_valid == 1'b0, "R8 one cycle", 64'(chg_valid), 64'h0);

        // R6: running task without done is not retriggered
        idle(3);
        check(task_trig == '0, "R6 no retrigger", 64'(task_trig), 64'h0);

        // R5: done on task 0 restarts it; R7: done on disabled task 5 ignored
        mask_a = '0; mask_a[0] = 1'b1; mask_a[5] = 1'b1;
        cyc(0, 0, '0, 0, mask_a);
        check(task_trig[0] == 1'b1, "R5 restart", 64'(task_trig), 64'h1);
        check(task_trig[5] == 1'b0, "R7 idle done", 64'(task_trig[5]), 64'h0);

        // R7: disable task 16 while running, its done is ignored
        cyc(1, 1, 16'h8000, 1, '0);
        mask_a = '0; mask_a[16] = 1'b1;
        cyc(0, 0, '0, 0, mask_a);
        check(task_trig[16] == 1'b0, "R7 disabled done", 64'(task_trig[16]), 64'h0);

        // R7: re-enable task 2 while running waits for done
        cyc(1, 0, 16'h0001, 1, '0);
        cyc(1, 0, 16'h0005, 1, '0);
        check(task_trig[2] == 1'b0, "R7 reenable busy", 64'(task_trig[2]), 64'h0);
        mask_a = '0; mask_a[2] = 1'b1;
        cyc(0, 0, '0, 0, mask_a);
        check(task_trig[2] == 1'b1, "R7 reenable done", 64'(task_trig[2]), 64'h1);

        // R9: commit of an unchanged mask
        s_prev = chg_stamp;
        cyc(0, 0, '0, 1, '0);
        check(chg_valid == 1'b0, "R9 no chg", 64'(chg_valid), 64'h0);
        check(chg_stamp == s_prev, "R9 stamp hold", 64'(chg_stamp), 64'(s_prev));

        // R10: out-of-range address and dropped top bits
        cyc(1, 5, 16'hFFFF, 1, '0);
        check(chg_valid == 1'b0, "R10 bad addr", 64'(chg_valid), 64'h0);
        peek(5, '0, "R10 bad addr read");
        cyc(1, 3, 16'hFFFF, 1, '0);
        check(task_trig[59:48] == 12'hFFF, "R10 top word start", 64'(task_trig[59:48]), 64'hFFF);
        peek(3, 16'h0FFF, "R10 top word read");

        // Random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] dn;
            bit wr, cm;
            int a;
            dn = '0;
            for (int i = 0; i < N; i++) begin
                if ((m_busy[i] && ($urandom % 6 == 0)) || ($urandom % 64 == 0)) dn[i] = 1'b1;
            end
            wr = ($urandom % 8 == 0);
            cm = ($urandom % 16 == 0);
            a  = $urandom % (1 << AW);
            cyc(wr, a, W'($urandom), cm, dn);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule